// File: doc/BRIEF.md
# UART Burst FIFO Access Port

This block is the register-side front end of a UART. It holds the receive and transmit byte FIFOs and lets a host on a simple 32-bit memory-mapped bus move data through them either one byte or four bytes per access. The serialiser on the line side pushes received bytes, tagged with parity and framing flags, into the receive FIFO. It takes bytes to send from the head of the transmit FIFO.

The host reads one status word to learn everything it needs before it moves data. That word holds the receive fill level, the free space in the transmit FIFO, an interrupt flag with inverted sense, and a copy of the classic line status byte. A word read on the receive port drains up to four bytes at once, packed little-endian. A word write on the transmit port queues four bytes at once, or none of them.

Top module: `uart_burst_port`

## Requirements
- R1: Status bits 7:0 give the receive FIFO fill level and bits 15:8 give the transmit FIFO free entries. Both saturate at 255, so with the default depth of 256 an empty transmit FIFO reads 0xFF.
- R2: Status bit 20 is the inverse of `irq_pend`. Bits 19:16, 21, 23, 28 and 30 always read 0.
- R3: Status bit 24 is set while the receive FIFO is not empty. Bit 29 is set while the transmit FIFO is empty.
- R4: Status bit 26 is the parity flag and bit 27 the framing flag of the oldest receive byte. Both read 0 when that FIFO is empty. Bit 31 is set while any byte held in the receive FIFO carries either flag.
- R5: A line push into a full receive FIFO is dropped, even if the host pops in the same cycle. It sets the sticky overrun flag at status bit 25.
- R6: A write to the FIFO control address (0x02) whose low byte is 0x43 clears the overrun flag and the write-error flag. Any other value written there has no effect.
- R7: A read of the receive word address (0x18) pops min(4, fill) bytes. It returns the oldest byte in bits 7:0, the next in 15:8, and so on, with lanes beyond the popped bytes read as 0.
- R8: A read of the data address (0x00) pops one receive byte and returns it in bits 7:0 with bits 31:8 zero. When the FIFO is empty it returns 0 and pops nothing.
- R9: A write to the transmit word address (0x14) with at least four free entries queues four bytes, sent in the order bits 7:0, 15:8, 23:16, 31:24.
- R10: A transmit word write with fewer than four free entries, or a byte write to a full transmit FIFO, is dropped whole. Either one sets the sticky write-error flag at status bit 22.
- R11: A write to the data address (0x00) queues bits 7:0 of the write data as one transmit byte.
- R12: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd` and holds until the next read. Reads of unmapped addresses return 0. Writes to unmapped addresses have no effect.
- R13: Synchronous active-low reset empties both FIFOs, clears both sticky flags and zeroes `bus_rdata`. The status word after reset is 0x2010FF00 with `irq_pend` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lin_rx_valid | input | 1 | Serialiser offers a received byte |
| lin_rx_data | input | 8 | Received byte |
| lin_rx_perr | input | 1 | Parity error on that byte |
| lin_rx_ferr | input | 1 | Framing error on that byte |
| lin_tx_pop | input | 1 | Serialiser takes the head transmit byte |
| lin_tx_data | output | 8 | Head byte of the transmit FIFO |
| lin_tx_ready | output | 1 | Transmit FIFO holds at least one byte |
| irq_pend | input | 1 | Interrupt pending from the interrupt logic |

## Verification
The assertions watch the properties that hold on every cycle. Neither FIFO is ever pushed past its depth or popped below empty. The count of flagged receive bytes never exceeds the fill level. The overrun and write-error flags set and stay set as the rules require. A full-width receive pop lowers the fill by exactly four, and read data stays stable between reads. The bench scenarios cover what only a known byte stream can show. These are the little-endian lane order and the zeroed tail of a partial word read, the order in which transmitted bytes leave, saturation of both counts at a depth of 256, the head-byte error bits, and the fact that control values other than the clear code do nothing.

// File: rtl/uart_burst_pkg.sv
// Shared constants and types for the UART burst FIFO access port.
// Assumes a 32-bit data bus made of four byte lanes.
package uart_burst_pkg;

    localparam int BYTE_W = 8;
    localparam int BURST  = 4;
    localparam int WORD_W = BYTE_W * BURST;
    localparam int ADDR_W = 8;

    // Register addresses (byte addresses)
    localparam logic [ADDR_W-1:0] A_DATA = 8'h00;
    localparam logic [ADDR_W-1:0] A_FCTL = 8'h02;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] A_TXW  = 8'h14;
    localparam logic [ADDR_W-1:0] A_RXW  = 8'h18;

    // Control code that clears the sticky flags
    localparam logic [7:0] FCTL_CLR = 8'h43;

    // Status word bit positions
    localparam int ST_RXCNT  = 0;
    localparam int ST_TXFREE = 8;
    localparam int ST_NOINT  = 20;
    localparam int ST_WERR   = 22;
    localparam int ST_DR     = 24;
    localparam int ST_OVR    = 25;
    localparam int ST_PE     = 26;
    localparam int ST_FE     = 27;
    localparam int ST_THRE   = 29;
    localparam int ST_ANYERR = 31;

    // One receive FIFO entry: byte plus its line error flags
    typedef struct packed {
        logic                ferr;
        logic                perr;
        logic [BYTE_W-1:0]   data;
    } rx_ent_t;

    localparam int RX_ENT_W = $bits(rx_ent_t);

endpackage

// File: rtl/burst_fifo.sv
// Multi-lane FIFO: accepts 0..LANES entries per cycle and releases
// 0..LANES entries per cycle, exposing the oldest LANES entries.
// Assumes DEPTH is a power of two and the caller never asks for more
// pushes than free room or more pops than the fill level.
module burst_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NW-1:0]          push_n,
    input  logic [LANES*WIDTH-1:0] push_data,
    input  logic [NW-1:0]          pop_n,
    output logic [LANES*WIDTH-1:0] peek_data,
    output logic [CW-1:0]          count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Storage write: place each accepted lane at consecutive slots
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (NW'(l) < push_n) begin
                mem[wr_ptr + AW'(l)] <= push_data[l*WIDTH +: WIDTH];
            end
        end
    end

    // Pointer and fill-level update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // Head window: the oldest LANES entries, oldest in lane 0
    for (genvar l = 0; l < LANES; l++) begin : g_peek
        assign peek_data[l*WIDTH +: WIDTH] = mem[rd_ptr + AW'(l)];
    end

    // R5 / R10: callers never push beyond the free room
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(push_n) + int'(count)) <= DEPTH);

    // R7 / R8: callers never pop more than is held
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(count));

endmodule

// File: rtl/rx_err_tally.sv
// Counts how many entries of the receive FIFO carry a parity or
// framing flag, so a single bit can report an error anywhere inside.
// Assumes pop_n selects the leading lanes of lane_bad.
module rx_err_tally #(
    parameter int DEPTH = 256,
    parameter int LANES = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_bad,
    input  logic [NW-1:0]    pop_n,
    input  logic [LANES-1:0] lane_bad,
    input  logic [CW-1:0]    fifo_count,
    output logic             any_bad
);

    logic [CW-1:0] bad_cnt;
    logic [NW-1:0] bad_out;

    // Number of flagged entries leaving in this cycle
    always_comb begin
        bad_out = '0;
        for (int l = 0; l < LANES; l++) begin
            if (NW'(l) < pop_n && lane_bad[l]) begin
                bad_out = bad_out + NW'(1);
            end
        end
    end

    // Running count of flagged entries held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_cnt <= '0;
        end else begin
            bad_cnt <= bad_cnt + CW'(push && push_bad) - CW'(bad_out);
        end
    end

    assign any_bad = (bad_cnt != '0);

    // R4: flagged entries can never outnumber stored entries
    p_err_le_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cnt <= fifo_count);

endmodule

// File: rtl/uart_burst_stat.sv
// Packs fill levels, sticky flags and head-entry error bits into the
// single 32-bit status word. Purely combinational.
// Assumes counts never exceed DEPTH.
module uart_burst_stat
    import uart_burst_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]     rx_cnt,
    input  logic [CW-1:0]     tx_cnt,
    input  logic              head_perr,
    input  logic              head_ferr,
    input  logic              err_any,
    input  logic              overrun,
    input  logic              wr_err,
    input  logic              irq_pend,
    output logic [WORD_W-1:0] word
);

    logic [CW-1:0] tx_free;

    // Clamp a fill value to one byte
    function automatic logic [7:0] sat8(input logic [CW-1:0] v);
        return (int'(v) >= 255) ? 8'hFF : v[7:0];
    endfunction

    assign tx_free = CW'(DEPTH) - tx_cnt;

    // Assemble the status word field by field
    always_comb begin
        word                 = '0;
        word[ST_RXCNT +: 8]  = sat8(rx_cnt);
        word[ST_TXFREE +: 8] = sat8(tx_free);
        word[ST_NOINT]       = !irq_pend;
        word[ST_WERR]        = wr_err;
        word[ST_DR]          = (rx_cnt != '0);
        word[ST_OVR]         = overrun;
        word[ST_PE]          = (rx_cnt != '0) && head_perr;
        word[ST_FE]          = (rx_cnt != '0) && head_ferr;
        word[ST_THRE]        = (tx_cnt == '0);
        word[ST_ANYERR]      = err_any;
    end

endmodule

// File: rtl/uart_burst_port.sv
// UART burst FIFO access port: bus-side decode for byte and word
// data ports, the status word, and the flag-clear command. Holds
// the receive and transmit FIFOs.
// Assumes bus_rd and bus_wr are never high together.
module uart_burst_port
    import uart_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 256,
    localparam int CW = $clog2(FIFO_DEPTH + 1),
    localparam int NW = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              lin_rx_valid,
    input  logic [BYTE_W-1:0] lin_rx_data,
    input  logic              lin_rx_perr,
    input  logic              lin_rx_ferr,
    input  logic              lin_tx_pop,
    output logic [BYTE_W-1:0] lin_tx_data,
    output logic              lin_tx_ready,
    input  logic              irq_pend
);

    // Access decode
    logic rd_stat, rd_rxw, rd_rxb, rd_known;
    logic wr_txw, wr_txb, wr_fctl, fctl_clear;

    assign rd_stat    = bus_rd && (bus_addr == A_STAT);
    assign rd_rxw     = bus_rd && (bus_addr == A_RXW);
    assign rd_rxb     = bus_rd && (bus_addr == A_DATA);
    assign rd_known   = rd_stat || rd_rxw || rd_rxb;
    assign wr_txw     = bus_wr && (bus_addr == A_TXW);
    assign wr_txb     = bus_wr && (bus_addr == A_DATA);
    assign wr_fctl    = bus_wr && (bus_addr == A_FCTL);
    assign fctl_clear = wr_fctl && (bus_wdata[7:0] == FCTL_CLR);

    // Receive FIFO
    logic [CW-1:0]             rx_cnt;
    logic [BURST*RX_ENT_W-1:0] rx_peek;
    logic [BURST*RX_ENT_W-1:0] rx_push_data;
    logic [NW-1:0]             rx_push_n, rx_pop_n, rx_avail;
    logic                      rx_full, rx_take, rx_drop;
    rx_ent_t                   rx_lane [BURST];
    logic [BURST-1:0]          rx_lane_bad;

    assign rx_full  = (rx_cnt == CW'(FIFO_DEPTH));
    assign rx_take  = lin_rx_valid && !rx_full;
    assign rx_drop  = lin_rx_valid && rx_full;
    assign rx_push_n = rx_take ? NW'(1) : NW'(0);
    assign rx_push_data = {{((BURST-1)*RX_ENT_W){1'b0}},
                           rx_ent_t'{ferr: lin_rx_ferr, perr: lin_rx_perr,
                                     data: lin_rx_data}};
    assign rx_avail = (int'(rx_cnt) >= BURST) ? NW'(BURST) : NW'(rx_cnt);

    // Receive pop amount chosen by the access type
    always_comb begin
        rx_pop_n = '0;
        if (rd_rxw) begin
            rx_pop_n = rx_avail;
        end else if (rd_rxb && rx_cnt != '0) begin
            rx_pop_n = NW'(1);
        end
    end

    for (genvar l = 0; l < BURST; l++) begin : g_rx_lane
        assign rx_lane[l]     = rx_ent_t'(rx_peek[l*RX_ENT_W +: RX_ENT_W]);
        assign rx_lane_bad[l] = rx_lane[l].perr || rx_lane[l].ferr;
    end

    burst_fifo #(
        .WIDTH (RX_ENT_W),
        .DEPTH (FIFO_DEPTH),
        .LANES (BURST)
    ) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data (rx_push_data),
        .pop_n     (rx_pop_n),
        .peek_data (rx_peek),
        .count     (rx_cnt)
    );

    logic rx_err_any;

    rx_err_tally #(
        .DEPTH (FIFO_DEPTH),
        .LANES (BURST)
    ) i_rx_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_take),
        .push_bad   (lin_rx_perr || lin_rx_ferr),
        .pop_n      (rx_pop_n),
        .lane_bad   (rx_lane_bad),
        .fifo_count (rx_cnt),
        .any_bad    (rx_err_any)
    );

    // Transmit FIFO
    logic [CW-1:0]           tx_cnt, tx_free;
    logic [BURST*BYTE_W-1:0] tx_peek, tx_push_data;
    logic [NW-1:0]           tx_push_n, tx_pop_n;
    logic                    wr_drop;

    assign tx_free = CW'(FIFO_DEPTH) - tx_cnt;

    // Transmit push amount and lane data chosen by the access type
    always_comb begin
        tx_push_n    = '0;
        tx_push_data = bus_wdata;
        wr_drop      = 1'b0;
        if (wr_txw) begin
            if (int'(tx_free) >= BURST) tx_push_n = NW'(BURST);
            else                        wr_drop   = 1'b1;
        end else if (wr_txb) begin
            tx_push_data = {{((BURST-1)*BYTE_W){1'b0}}, bus_wdata[BYTE_W-1:0]};
            if (tx_free != '0) tx_push_n = NW'(1);
            else               wr_drop   = 1'b1;
        end
    end

    assign tx_pop_n = (lin_tx_pop && tx_cnt != '0) ? NW'(1) : NW'(0);

    burst_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (FIFO_DEPTH),
        .LANES (BURST)
    ) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_pop_n),
        .peek_data (tx_peek),
        .count     (tx_cnt)
    );

    assign lin_tx_data  = tx_peek[BYTE_W-1:0];
    assign lin_tx_ready = (tx_cnt != '0);

    // Sticky flags
    logic overrun_q, wr_err_q;

    // Overrun and write-error: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
            wr_err_q  <= 1'b0;
        end else begin
            if (rx_drop)         overrun_q <= 1'b1;
            else if (fctl_clear) overrun_q <= 1'b0;
            if (wr_drop)         wr_err_q  <= 1'b1;
            else if (fctl_clear) wr_err_q  <= 1'b0;
        end
    end

    // Status word
    logic [WORD_W-1:0] status_word;

    uart_burst_stat #(
        .DEPTH (FIFO_DEPTH)
    ) i_stat (
        .rx_cnt    (rx_cnt),
        .tx_cnt    (tx_cnt),
        .head_perr (rx_lane[0].perr),
        .head_ferr (rx_lane[0].ferr),
        .err_any   (rx_err_any),
        .overrun   (overrun_q),
        .wr_err    (wr_err_q),
        .irq_pend  (irq_pend),
        .word      (status_word)
    );

    // Receive word packing: oldest byte in the lowest lane
    logic [WORD_W-1:0] rx_word;

    always_comb begin
        rx_word = '0;
        for (int l = 0; l < BURST; l++) begin
            if (NW'(l) < rx_avail) rx_word[l*BYTE_W +: BYTE_W] = rx_lane[l].data;
        end
    end

    // Read data register, loaded only by a read access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (rd_stat)                    bus_rdata <= status_word;
            else if (rd_rxw)                bus_rdata <= rx_word;
            else if (rd_rxb && rx_cnt != '0) bus_rdata <= {{(WORD_W-BYTE_W){1'b0}}, rx_lane[0].data};
            else                            bus_rdata <= '0;
        end
    end

    // R5: a push into a full receive FIFO raises overrun next cycle
    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_rx_valid && rx_full) |=> status_word[ST_OVR]);

    // R6: overrun only falls after the clear command
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[ST_OVR] && !fctl_clear) |=> status_word[ST_OVR]);

    // R10: a refused word write raises the write-error flag
    p_wrerr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txw && int'(tx_free) < BURST) |=> status_word[ST_WERR]);

    // R7: a full-width receive read removes exactly four entries
    p_word_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxw && int'(rx_cnt) >= BURST) |=>
        (rx_cnt == $past(rx_cnt) - CW'(BURST) + CW'($past(rx_push_n))));

    // R12: read data holds between reads
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R12: reads and writes never overlap
    p_rw_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R12: unmapped reads return zero
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_known) |=> (bus_rdata == '0));

endmodule

// File: tb/test_uart_burst_port.sv
// Self-checking bench for uart_burst_port: a vector table walked by
// one loop, then directed tests for saturation, refusal, and reset.
module test_uart_burst_port;
    import uart_burst_pkg::*;

    localparam int DEPTH = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic              lin_rx_valid = 1'b0;
    logic [7:0]        lin_rx_data = '0;
    logic              lin_rx_perr = 1'b0;
    logic              lin_rx_ferr = 1'b0;
    logic              lin_tx_pop = 1'b0;
    logic [7:0]        lin_tx_data;
    logic              lin_tx_ready;
    logic              irq_pend = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    uart_burst_port #(.FIFO_DEPTH(DEPTH)) i_uart_burst_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .lin_rx_valid (lin_rx_valid),
        .lin_rx_data  (lin_rx_data),
        .lin_rx_perr  (lin_rx_perr),
        .lin_rx_ferr  (lin_rx_ferr),
        .lin_tx_pop   (lin_tx_pop),
        .lin_tx_data  (lin_tx_data),
        .lin_tx_ready (lin_tx_ready),
        .irq_pend     (irq_pend)
    );

    always #10 clk = ~clk;

    localparam logic [1:0] OP_PUSH = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_POP = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{OP_PUSH, 4'd3,  8'h00, 32'h011, 32'h0},        // R3 feed
        '{OP_PUSH, 4'd4,  8'h00, 32'h122, 32'h0},        // R4 parity flagged
        '{OP_PUSH, 4'd3,  8'h00, 32'h033, 32'h0},
        '{OP_PUSH, 4'd4,  8'h00, 32'h244, 32'h0},        // R4 framing flagged
        '{OP_PUSH, 4'd3,  8'h00, 32'h055, 32'h0},
        '{OP_RD,   4'd1,  A_STAT, 32'h0, 32'hA110FF05},  // R1 R3 R4 levels
        '{OP_RD,   4'd7,  A_RXW,  32'h0, 32'h44332211},  // R7 little-endian
        '{OP_RD,   4'd4,  A_STAT, 32'h0, 32'h2110FF01},  // R4 error gone
        '{OP_RD,   4'd7,  A_RXW,  32'h0, 32'h00000055},  // R7 partial word
        '{OP_RD,   4'd3,  A_STAT, 32'h0, 32'h2010FF00},  // R3 drained
        '{OP_RD,   4'd8,  A_DATA, 32'h0, 32'h00000000},  // R8 empty byte read
        '{OP_WR,   4'd9,  A_TXW,  32'hDDCCBBAA, 32'h0},  // R9
        '{OP_WR,   4'd11, A_DATA, 32'h000001EE, 32'h0},  // R11
        '{OP_RD,   4'd1,  A_STAT, 32'h0, 32'h0010FB00},  // R1 tx free 251
        '{OP_POP,  4'd9,  8'h00, 32'h0, 32'h000000AA},   // R9 order
        '{OP_POP,  4'd9,  8'h00, 32'h0, 32'h000000BB},
        '{OP_POP,  4'd9,  8'h00, 32'h0, 32'h000000CC},
        '{OP_POP,  4'd9,  8'h00, 32'h0, 32'h000000DD},
        '{OP_POP,  4'd11, 8'h00, 32'h0, 32'h000000EE},   // R11 low byte only
        '{OP_RD,   4'd3,  A_STAT, 32'h0, 32'h2010FF00},  // R3 tx empty again
        '{OP_WR,   4'd12, 8'h30,  32'hFFFFFFFF, 32'h0},  // R12 unmapped write
        '{OP_RD,   4'd12, 8'h30,  32'h0, 32'h00000000},  // R12 unmapped read
        '{OP_PUSH, 4'd4,  8'h00, 32'h166, 32'h0},
        '{OP_RD,   4'd4,  A_STAT, 32'h0, 32'hA510FF01},  // R4 head parity
        '{OP_RD,   4'd8,  A_DATA, 32'h0, 32'h00000066},  // R8
        '{OP_PUSH, 4'd4,  8'h00, 32'h277, 32'h0},
        '{OP_RD,   4'd4,  A_STAT, 32'h0, 32'hA910FF01},  // R4 head framing
        '{OP_RD,   4'd8,  A_DATA, 32'h0, 32'h00000077},  // R8
        '{OP_WR,   4'd6,  A_FCTL, 32'h000000FF, 32'h0},  // R6 other value
        '{OP_RD,   4'd6,  A_STAT, 32'h0, 32'h2010FF00}   // R6 no effect
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic line_push(input logic [7:0] d, input logic pe, input logic fe);
        lin_rx_valid = 1'b1; lin_rx_data = d; lin_rx_perr = pe; lin_rx_ferr = fe;
        step();
        lin_rx_valid = 1'b0; lin_rx_perr = 1'b0; lin_rx_ferr = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic line_pop(output logic [7:0] v);
        v = lin_tx_data;
        lin_tx_pop = 1'b1;
        step();
        lin_tx_pop = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;

        // R13: reset state
        repeat (3) step();
        check("R13 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        step();
        check("R13 tx ready after reset", {31'b0, lin_tx_ready}, 32'h0);
        bus_read(A_STAT, v);
        check("R13 R2 status after reset", v, 32'h2010FF00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_PUSH: line_push(VEC[i].data[7:0], VEC[i].data[8], VEC[i].data[9]);
                OP_WR:   bus_write(VEC[i].addr, VEC[i].data);
                OP_RD: begin
                    bus_read(VEC[i].addr, v);
                    check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
                end
                default: begin
                    line_pop(b);
                    check($sformatf("R%0d vector %0d", VEC[i].req, i), {24'h0, b}, VEC[i].exp);
                end
            endcase
        end

        // R2: interrupt flag inverted
        irq_pend = 1'b1;
        bus_read(A_STAT, v);
        check("R2 bit20 with irq pending", v, 32'h2000FF00);
        irq_pend = 1'b0;

        // R12: read data holds across a write
        bus_read(A_STAT, v);
        bus_write(A_FCTL, 32'h0);
        check("R12 rdata held", bus_rdata, 32'h2010FF00);

        // R1 R5 R6: fill receive FIFO to depth, overrun, clear
        for (int i = 0; i < DEPTH; i++) line_push(8'(i), 1'b0, 1'b0);
        bus_read(A_STAT, v);
        check("R1 rx count saturated", v, 32'h2110FFFF);
        line_push(8'hAB, 1'b0, 1'b0);
        bus_read(A_STAT, v);
        check("R5 overrun set", v, 32'h2310FFFF);
        bus_write(A_FCTL, 32'h42);
        bus_read(A_STAT, v);
        check("R6 wrong code keeps overrun", v, 32'h2310FFFF);
        bus_write(A_FCTL, 32'h43);
        bus_read(A_STAT, v);
        check("R6 clear code", v, 32'h2110FFFF);
        for (int i = 0; i < DEPTH / 4; i++) begin
            bus_read(A_RXW, v);
            check("R7 R5 drain order", v,
                  {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        end
        bus_read(A_STAT, v);
        check("R5 dropped byte absent", v, 32'h2010FF00);

        // R9 R10: fill transmit FIFO, refused writes
        for (int i = 0; i < DEPTH / 4; i++)
            bus_write(A_TXW, {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        bus_read(A_STAT, v);
        check("R1 tx free zero", v, 32'h00100000);
        bus_write(A_DATA, 32'h99);
        bus_read(A_STAT, v);
        check("R10 byte write to full", v, 32'h00500000);
        bus_write(A_FCTL, 32'h43);
        bus_read(A_STAT, v);
        check("R6 clears write error", v, 32'h00100000);
        bus_write(A_TXW, 32'h04030201);
        bus_read(A_STAT, v);
        check("R10 word write to full", v, 32'h00500000);
        line_pop(b);
        check("R9 first out", {24'h0, b}, 32'h0);
        bus_write(A_TXW, 32'h04030201);
        bus_read(A_STAT, v);
        check("R10 word write with one free", v, 32'h00500100);
        for (int i = 1; i < 4; i++) begin
            line_pop(b);
            check("R9 stream", {24'h0, b}, 32'(i));
        end
        bus_write(A_TXW, 32'h04030201);
        bus_read(A_STAT, v);
        check("R10 word write with four free", v, 32'h00500000);
        for (int i = 4; i < DEPTH; i++) begin
            line_pop(b);
            check("R9 stream", {24'h0, b}, 32'(i & 8'hFF));
        end
        for (int i = 1; i <= 4; i++) begin
            line_pop(b);
            check("R10 accepted tail", {24'h0, b}, 32'(i));
        end
        check("R3 tx ready low", {31'b0, lin_tx_ready}, 32'h0);

        // R13: reset with traffic pending
        line_push(8'h5A, 1'b1, 1'b0);
        bus_write(A_DATA, 32'h3C);
        bus_read(A_STAT, v);
        rst_n = 1'b0;
        step();
        step();
        check("R13 rdata cleared", bus_rdata, 32'h0);
        rst_n = 1'b1;
        step();
        check("R13 tx emptied", {31'b0, lin_tx_ready}, 32'h0);
        bus_read(A_STAT, v);
        check("R13 status after mid-run reset", v, 32'h2010FF00);

        summary();
    end

endmodule